// File: doc/BRIEF.md
# Burst Address Counter with Strobe Load

This block produces the address for each access on one port of a synchronous memory. On every rising edge of the port clock, three active-low controls decide what the address register does next. It can copy an address presented from outside, step its current value up by one to walk through a burst, keep its value, or go back to zero. The register output is the address the memory uses for the access in that cycle.

The block has no chip-enable input. Clearing and stepping therefore take effect whether or not the memory is selected. An address on the external bus reaches the register only when the strobe is asserted. In every other cycle the stored address is used again or advanced. An asynchronous active-low system reset clears the register. Its release passes through a synchronizer, so the counter starts to respond a fixed number of edges after reset is removed.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst_n` is low, `addr` is zero, with no need for a clock edge. Once `rst_n` rises, `addr` stays zero for the next SYNC_STAGES (default 2) rising edges whatever the controls do. The first control takes effect on edge SYNC_STAGES+1.
- R2: A low `clr_n` at a rising edge makes `addr` zero after that edge, whatever `strobe_n`, `cnt_en_n` and `ext_addr` are.
- R3: With `clr_n` high and `strobe_n` low at a rising edge, `addr` takes the value of `ext_addr` after that edge, whether `cnt_en_n` is high or low.
- R4: With `clr_n` and `strobe_n` high and `cnt_en_n` low at a rising edge, `addr` becomes its previous value plus one.
- R5: With all three controls high at a rising edge, `addr` keeps its value and `ext_addr` has no effect.
- R6: Stepping from the all-ones address gives zero.
- R7: The address width is the parameter AW, default 16. With the default, the full value 16'hFFFF can be loaded and read back on `addr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low system reset |
| ext_addr | input | AW | Address offered from outside |
| strobe_n | input | 1 | Active-low load of `ext_addr` |
| cnt_en_n | input | 1 | Active-low step by one |
| clr_n | input | 1 | Active-low clear to zero, highest priority |
| addr | output | AW | Internal address used for the current access |

## Verification
Clear, load and step can all be asserted in the same cycle. The vector table drives these combinations on purpose: clear together with an active strobe and an active step, and strobe together with an active step. Each result is judged against the fixed order clear, then load, then step, then hold. A second collision lies between reset release and a pending strobe. The directed test releases `rst_n` while the strobe is held low and checks that the load appears only on the third edge.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;
  // Action selected for the address register at the next edge
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_INC  = 2'd1,
    OP_LOAD = 2'd2,
    OP_CLR  = 2'd3
  } addr_op_e;
endpackage

// File: rtl/burst_rst_sync.sv
module burst_rst_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  localparam int NST = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

  logic [NST-1:0] stage_q;
  logic [NST-1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[NST-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign rst_q_n = stage_q[NST-1];
endmodule

// File: rtl/burst_op_decode.sv
module burst_op_decode
  import burst_addr_pkg::*;
(
  input  logic     clr_n,
  input  logic     strobe_n,
  input  logic     cnt_en_n,
  output addr_op_e op
);
  // Fixed priority: clear, load, step, hold
  always_comb begin
    if (!clr_n)         op = OP_CLR;
    else if (!strobe_n) op = OP_LOAD;
    else if (!cnt_en_n) op = OP_INC;
    else                op = OP_HOLD;
  end
endmodule

// File: rtl/burst_addr_next.sv
module burst_addr_next
  import burst_addr_pkg::*;
#(
  parameter int AW = 16
) (
  input  addr_op_e      op,
  input  logic [AW-1:0] cur,
  input  logic [AW-1:0] ext,
  output logic [AW-1:0] nxt,
  output logic          upd
);
  localparam logic [AW-1:0] ONE = AW'(1);

  always_comb begin
    nxt = cur;
    upd = 1'b1;
    unique case (op)
      OP_CLR:  nxt = '0;
      OP_LOAD: nxt = ext;
      OP_INC:  nxt = cur + ONE;   // natural wrap at all-ones
      default: upd = 1'b0;
    endcase
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_addr_pkg::*;
#(
  parameter int AW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ext_addr,
  input  logic          strobe_n,
  input  logic          cnt_en_n,
  input  logic          clr_n,
  output logic [AW-1:0] addr
);
  logic          rst_q_n;
  addr_op_e      op;
  logic [AW-1:0] addr_q;
  logic [AW-1:0] addr_d;
  logic          addr_ce;

  burst_rst_sync #(.SYNC_STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_q_n(rst_q_n)
  );

  burst_op_decode u_dec (
    .clr_n   (clr_n),
    .strobe_n(strobe_n),
    .cnt_en_n(cnt_en_n),
    .op      (op)
  );

  burst_addr_next #(.AW(AW)) u_nxt (
    .op (op),
    .cur(addr_q),
    .ext(ext_addr),
    .nxt(addr_d),
    .upd(addr_ce)
  );

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)     addr_q <= '0;
    else if (addr_ce) addr_q <= addr_d;
  end

  assign addr = addr_q;
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_q_n,
  input logic          clr_n,
  input logic          strobe_n,
  input logic          cnt_en_n,
  input logic [AW-1:0] ext_addr,
  input logic [AW-1:0] addr
);
  assert_reset_zero_R1: assert property (@(posedge clk)
    !rst_q_n |-> addr == '0);

  assert_clear_wins_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
    !clr_n |=> addr == '0);

  assert_strobe_load_R3: assert property (@(posedge clk) disable iff (!rst_q_n)
    (clr_n && !strobe_n) |=> addr == $past(ext_addr));

  assert_step_one_R4: assert property (@(posedge clk) disable iff (!rst_q_n)
    (clr_n && strobe_n && !cnt_en_n) |=> addr == AW'($past(addr) + AW'(1)));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_q_n)
    (clr_n && strobe_n && cnt_en_n) |=> $stable(addr));

  assert_wrap_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
    (clr_n && strobe_n && !cnt_en_n && addr == '1) |=> addr == '0);
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.AW(AW)) u_chk (
  .clk     (clk),
  .rst_q_n (rst_q_n),
  .clr_n   (clr_n),
  .strobe_n(strobe_n),
  .cnt_en_n(cnt_en_n),
  .ext_addr(ext_addr),
  .addr    (addr)
);

// File: tb/tb_burst_addr_gen.sv
module tb_burst_addr_gen;
  localparam int AW = 16;

  typedef struct packed {
    logic          clr_n;
    logic          strb_n;
    logic          en_n;
    logic [AW-1:0] ext;
    logic [AW-1:0] exp;
    logic [3:0]    req;
  } vec_t;

  localparam int NV = 13;
  // Applied in order after reset, starting from address zero
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 1'b1, 16'h1234, 16'h1234, 4'd3}, // R3 load
    '{1'b1, 1'b1, 1'b0, 16'h0000, 16'h1235, 4'd4}, // R4 step
    '{1'b1, 1'b1, 1'b0, 16'h9999, 16'h1236, 4'd4}, // R4 step, bus ignored
    '{1'b1, 1'b1, 1'b1, 16'hAAAA, 16'h1236, 4'd5}, // R5 hold
    '{1'b1, 1'b0, 1'b0, 16'h00FF, 16'h00FF, 4'd3}, // R3 load beats step
    '{1'b1, 1'b1, 1'b0, 16'h0000, 16'h0100, 4'd4}, // R4 carry
    '{1'b0, 1'b0, 1'b0, 16'h5555, 16'h0000, 4'd2}, // R2 clear beats both
    '{1'b1, 1'b0, 1'b1, 16'hFFFE, 16'hFFFE, 4'd3}, // R3
    '{1'b1, 1'b1, 1'b0, 16'h0000, 16'hFFFF, 4'd7}, // R7 full width
    '{1'b1, 1'b1, 1'b0, 16'h0000, 16'h0000, 4'd6}, // R6 wrap
    '{1'b1, 1'b1, 1'b1, 16'h7777, 16'h0000, 4'd5}, // R5
    '{1'b1, 1'b0, 1'b1, 16'h0F0F, 16'h0F0F, 4'd3}, // R3
    '{1'b0, 1'b1, 1'b1, 16'h3333, 16'h0000, 4'd2}  // R2 clear alone
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] ext_addr;
  logic          strobe_n, cnt_en_n, clr_n;
  logic [AW-1:0] addr;
  int            total = 0;
  int            bad   = 0;

  always #4 clk = ~clk;

  burst_addr_gen #(.AW(AW)) dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .ext_addr(ext_addr),
    .strobe_n(strobe_n),
    .cnt_en_n(cnt_en_n),
    .clr_n   (clr_n),
    .addr    (addr)
  );

  task automatic check(input logic [AW-1:0] exp, input string tag);
    total++;
    if (addr !== exp) begin
      bad++;
      $display("FAIL %s: addr=%h expected=%h", tag, addr, exp);
    end
  endtask

  task automatic drive(input logic c, input logic s, input logic e,
                       input logic [AW-1:0] a);
    clr_n = c; strobe_n = s; cnt_en_n = e; ext_addr = a;
  endtask

  initial begin
    #160000;
    bad++;
    $display("FAIL watchdog: run did not finish");
    $display("test done: total=%0d bad=%0d", total + 1, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    drive(1'b1, 1'b0, 1'b0, 16'hBEEF);
    repeat (3) @(negedge clk);
    check(16'h0000, "R1 held in reset");
    drive(1'b1, 1'b1, 1'b1, 16'h0000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(16'h0000, "R1 after release");

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].clr_n, VECS[i].strb_n, VECS[i].en_n, VECS[i].ext);
      @(negedge clk);
      total++;
      if (addr !== VECS[i].exp) begin
        bad++;
        $display("FAIL R%0d vector %0d: addr=%h expected=%h",
                 VECS[i].req, i, addr, VECS[i].exp);
      end
    end

    // R1: reset clears asynchronously in mid-cycle
    drive(1'b1, 1'b0, 1'b1, 16'hC3C3);
    @(negedge clk);
    check(16'hC3C3, "R3 before async reset");
    drive(1'b1, 1'b1, 1'b1, 16'h0000);
    #2 rst_n = 1'b0;
    #1 check(16'h0000, "R1 async clear");
    @(negedge clk);
    // R1: release with strobe already pending; load only on third edge
    drive(1'b1, 1'b0, 1'b1, 16'h4321);
    rst_n = 1'b1;
    @(negedge clk);
    check(16'h0000, "R1 release edge 1");
    @(negedge clk);
    check(16'h0000, "R1 release edge 2");
    @(negedge clk);
    check(16'h4321, "R1 first load edge 3");

    // R6: several steps around the wrap point
    drive(1'b1, 1'b0, 1'b1, 16'hFFFD);
    @(negedge clk);
    drive(1'b1, 1'b1, 1'b0, 16'h0000);
    repeat (4) @(negedge clk);
    check(16'h0001, "R6 multi-step wrap");

    // R5: many holds with a changing bus
    for (int k = 0; k < 4; k++) begin
      drive(1'b1, 1'b1, 1'b1, AW'(16'h1111 * (k + 1)));
      @(negedge clk);
    end
    check(16'h0001, "R5 long hold");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule